// File: doc/BRIEF.md
# Trusted-Module Command FIFO Register Block

This block is the device side of a small register window through which a host talks to a trusted module on one locality. A host bus selects one of four 32-bit registers: a locality control register, a status register, a byte-wide data port and a read-only identifier. The host first claims the locality, then puts the device into its ready state, streams a command into the data port, starts execution and finally drains the reply through the same data port.

Progress is reported without any software-visible counters. The status register shows whether command bytes are still owed, whether reply bytes are waiting and how many bytes can be moved right now. All three come from a 32-bit big-endian length held in bytes 2 to 5 of the byte stream. The command's own header sets the amount owed. The reply carries a length field of the same shape. Execution is a stand-in: after a fixed delay it produces a synthetic reply whose length comes from an input port. The reply echoes the first two command bytes, then holds its own length, then holds filler bytes.

Top module: `tm_fifo_regs`

## Requirements
- R1: After reset the control register reads 0x00000080: bit 7 (registers valid) is 1 and bit 5 (locality held) is 0. Status and data read 0. Register select codes are 0 control, 1 status, 2 data, 3 identifier.
- R2: Writing a word with bit 1 set to the control register claims the locality, and control then reads 0x000000A0. Writing a word with bit 5 set while the locality is held gives it up, and control reads 0x00000080 again. The release takes priority when both bits are set.
- R3: The identifier register returns the vendor code in bits 15:0 and the device code in bits 31:16, whether or not the locality is held.
- R4: The status bits are valid at bit 7, ready-for-command at bit 6, data-waiting at bit 4 and bytes-owed at bit 3. Bits 5 (start) and 1 (retry) always read 0. The move count sits at bits 23:8. With the locality held, writing status with bit 6 set enters the ready state. In that state status reads 0x000006C8.
- R5: The command length is the big-endian value in command bytes 2 to 5. Bytes-owed stays 1 until the byte that makes the count equal that length has been written. It reads 0 from the next cycle on.
- R6: While bytes are owed, the move count equals 6 minus the bytes received until six bytes are in. After that it equals the command length minus the bytes received.
- R7: A data write while bytes-owed is 0 is dropped. Status keeps its value, and the reply content does not change.
- R8: If the declared command length is below 6 or above MAX_CMD, bytes-owed clears as soon as the sixth byte arrives. A start request is then refused, and status stays at 0x000000C0.
- R9: Writing status with bit 5 set (and bit 6 clear), once a well-formed command is complete, starts execution. Status then reads 0x00000080. Data-waiting rises exactly EXEC_CYCLES clock edges after the edge that took the start write.
- R10: The reply length is rsp_len clamped to the range 6 to MAX_RSP. Reply byte 0 and byte 1 repeat command byte 0 and byte 1. Bytes 2 to 5 give the reply length big-endian. Byte i from 6 on is command byte 0 plus i, modulo 256. During the reply the move count is the number of bytes left.
- R11: Data-waiting clears once the last reply byte has been read, and status reads 0x00000080. A data read while nothing waits returns 0 and does not advance the reply.
- R12: Writing status with bit 6 set from any phase, including during a reply, drops the current transfer and returns to the ready state (0x000006C8).
- R13: While the locality is not held, status and data read 0, and data and status writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; a data read consumes one reply byte |
| bus_sel | input | 2 | Register select: 0 control, 1 status, 2 data, 3 identifier |
| bus_wdata | input | 32 | Write data; the data port uses bits 7:0 |
| bus_rdata | output | 32 | Read data for the selected register, combinational |
| rsp_len | input | 16 | Reply length requested from the execution stand-in, sampled at start |

## Verification
The assertions assume that the host issues at most one strobe per cycle and keeps bus_sel and bus_wdata steady while a strobe is high. They also assume that rsp_len does not change in the cycle a start is written. The stimulus drives every access from the falling clock edge for exactly one cycle, with a single strobe at a time. Between accesses it parks the select on the status register, so the running model comparison sees status on nearly every cycle. The bench sets rsp_len well before each start.

// File: rtl/tm_fifo_regs.sv
module tm_fifo_regs #(
  parameter int EXEC_CYCLES = 4,
  parameter int MAX_CMD     = 64,
  parameter int MAX_RSP     = 32,
  parameter logic [15:0] VENDOR_ID = 16'h1D0A,
  parameter logic [15:0] DEVICE_ID = 16'h0042
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_sel,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [15:0] rsp_len
);
  localparam int TW = $clog2(EXEC_CYCLES + 1);
  localparam logic [1:0] SEL_CTL = 2'd0, SEL_STS = 2'd1, SEL_DAT = 2'd2;

  typedef enum logic [2:0] {PH_IDLE, PH_FILL, PH_EXEC, PH_RESP, PH_DONE} phase_t;

  phase_t      phase;
  logic        granted;
  logic [15:0] cnt, rptr, rlen, burst;
  logic [7:0]  hdr [0:5];
  logic [7:0]  rsp_byte;
  logic [TW-1:0] timer;

  wire [31:0] cmd_len  = {hdr[2], hdr[3], hdr[4], hdr[5]};
  wire        hdr_done = cnt >= 16'd6;
  wire        len_ok   = (cmd_len >= 32'd6) && (cmd_len <= 32'(MAX_CMD));
  wire        cmd_owed = (phase == PH_FILL) && (!hdr_done || (len_ok && ({16'b0, cnt} < cmd_len)));
  wire        complete = (phase == PH_FILL) && hdr_done && len_ok && ({16'b0, cnt} == cmd_len);
  wire        rsp_avail = (phase == PH_RESP);
  wire        cmd_ready = (phase == PH_FILL);

  wire ctl_wr = bus_wr && bus_sel == SEL_CTL;
  wire sts_wr = bus_wr && bus_sel == SEL_STS && granted;
  wire dat_wr = bus_wr && bus_sel == SEL_DAT && granted;
  wire dat_rd = bus_rd && bus_sel == SEL_DAT && granted;

  wire [15:0] rsp_clamped = (rsp_len < 16'd6) ? 16'd6 :
                            (rsp_len > 16'(MAX_RSP)) ? 16'(MAX_RSP) : rsp_len;

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:8], bus_wdata[7], bus_wdata[4:2], bus_wdata[0]};

  always_comb begin
    if (cmd_owed)       burst = hdr_done ? (cmd_len[15:0] - cnt) : (16'd6 - cnt);
    else if (rsp_avail) burst = rlen - rptr;
    else                burst = 16'd0;
  end

  always_comb begin
    if (rptr < 16'd2)       rsp_byte = hdr[rptr[0] ? 1 : 0];
    else if (rptr == 16'd4) rsp_byte = rlen[15:8];
    else if (rptr == 16'd5) rsp_byte = rlen[7:0];
    else if (rptr < 16'd6)  rsp_byte = 8'h00;
    else                    rsp_byte = hdr[0] + rptr[7:0];
  end

  always_comb begin
    case (bus_sel)
      SEL_CTL: bus_rdata = {24'b0, 1'b1, 1'b0, granted, 5'b0};
      SEL_STS: bus_rdata = granted ? {8'b0, burst, 1'b1, cmd_ready, 1'b0, rsp_avail, cmd_owed, 3'b0} : 32'b0;
      SEL_DAT: bus_rdata = (granted && rsp_avail) ? {24'b0, rsp_byte} : 32'b0;
      default: bus_rdata = {DEVICE_ID, VENDOR_ID};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      granted <= 1'b0;
      cnt     <= '0;
      rptr    <= '0;
      rlen    <= '0;
      timer   <= '0;
      for (int i = 0; i < 6; i++) hdr[i] <= 8'h00;
    end else begin
      if (phase == PH_EXEC) begin
        if (timer == '0) phase <= PH_RESP;
        else             timer <= timer - 1'b1;
      end
      if (dat_wr && cmd_owed) begin
        if (cnt < 16'd6) hdr[cnt[2:0]] <= bus_wdata[7:0];
        cnt <= cnt + 16'd1;
      end
      if (dat_rd && rsp_avail) begin
        rptr <= rptr + 16'd1;
        if (rptr == rlen - 16'd1) phase <= PH_DONE;
      end
      if (sts_wr && bus_wdata[6]) begin
        phase <= PH_FILL;
        cnt   <= '0;
        rptr  <= '0;
      end else if (sts_wr && bus_wdata[5] && complete) begin
        phase <= PH_EXEC;
        timer <= TW'(EXEC_CYCLES - 1);
        rlen  <= rsp_clamped;
        rptr  <= '0;
      end
      if (ctl_wr) begin
        if (bus_wdata[5] && granted) begin
          granted <= 1'b0;
          phase   <= PH_IDLE;
          cnt     <= '0;
          rptr    <= '0;
        end else if (bus_wdata[1]) begin
          granted <= 1'b1;
        end
      end
    end
  end

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[5] && granted) |=> (!granted && phase == PH_IDLE));

  assert_expect_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmd_owed) && phase == PH_FILL) |-> (!len_ok || {16'b0, cnt} == cmd_len));

  assert_burst_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst != 16'd0) |-> (cmd_owed || rsp_avail));

  assert_ignored_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !cmd_owed) |=> $stable(cnt));

  assert_go_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && !bus_wdata[6] && bus_wdata[5] && complete) |=> (phase == PH_EXEC));

  assert_last_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !bus_wr && rsp_avail && rptr == rlen - 16'd1) |=> !rsp_avail);

  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !bus_wr && !rsp_avail) |=> $stable(rptr));
endmodule

// File: tb/tm_fifo_regs_test.sv
module tm_fifo_regs_test;
  localparam int EXC = 4, MCMD = 64, MRSP = 32;
  localparam logic [15:0] VID = 16'h1D0A, DID = 16'h0042;
  localparam logic [1:0] CTL = 0, STS = 1, DAT = 2, IDN = 3;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_sel = STS;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] rsp_len = 16'd8;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tm_fifo_regs #(.EXEC_CYCLES(EXC), .MAX_CMD(MCMD), .MAX_RSP(MRSP),
                 .VENDOR_ID(VID), .DEVICE_ID(DID)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rsp_len(rsp_len));

  // behavioural reference model: 0 idle, 1 ready/fill, 2 exec, 3 reply, 4 drained
  int m_g = 0, m_ph = 0, m_cnt = 0, m_rptr = 0, m_rlen = 0, m_wait = 0;
  byte unsigned m_h [6];

  function automatic longint m_len();
    return {m_h[2], m_h[3], m_h[4], m_h[5]};
  endfunction
  function automatic bit m_owed();
    if (m_ph != 1) return 0;
    if (m_cnt < 6) return 1;
    return (m_len() >= 6 && m_len() <= MCMD && m_cnt < m_len());
  endfunction
  function automatic bit m_complete();
    return m_ph == 1 && m_cnt >= 6 && m_len() >= 6 && m_len() <= MCMD && m_cnt == m_len();
  endfunction
  function automatic logic [7:0] m_byte(int i);
    if (i < 2) return m_h[i];
    if (i == 4) return m_rlen[15:8];
    if (i == 5) return m_rlen[7:0];
    if (i < 6) return 8'h00;
    return 8'(m_h[0] + i);
  endfunction
  function automatic logic [31:0] m_rdata(logic [1:0] s);
    int b;
    case (s)
      CTL: return m_g ? 32'hA0 : 32'h80;
      IDN: return {DID, VID};
      DAT: return (m_g && m_ph == 3) ? {24'b0, m_byte(m_rptr)} : 32'b0;
      default: begin
        if (!m_g) return 0;
        b = m_owed() ? (m_cnt < 6 ? 6 - m_cnt : int'(m_len()) - m_cnt) : (m_ph == 3 ? m_rlen - m_rptr : 0);
        return {8'b0, 16'(b), 1'b1, m_ph == 1, 1'b0, m_ph == 3, m_owed(), 3'b0};
      end
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_g = 0; m_ph = 0; m_cnt = 0; m_rptr = 0; m_rlen = 0; m_wait = 0;
      foreach (m_h[i]) m_h[i] = 0;
    end else begin
      bit owed, done, rdav;
      owed = m_owed(); done = m_complete(); rdav = (m_ph == 3);
      if (m_ph == 2) begin
        m_wait++;
        if (m_wait == EXC) m_ph = 3;
      end
      if (m_g && bus_wr && bus_sel == DAT && owed) begin
        if (m_cnt < 6) m_h[m_cnt] = bus_wdata[7:0];
        m_cnt++;
      end
      if (m_g && bus_rd && bus_sel == DAT && rdav) begin
        m_rptr++;
        if (m_rptr == m_rlen) m_ph = 4;
      end
      if (m_g && bus_wr && bus_sel == STS && bus_wdata[6]) begin
        m_ph = 1; m_cnt = 0; m_rptr = 0;
      end else if (m_g && bus_wr && bus_sel == STS && bus_wdata[5] && done) begin
        m_ph = 2; m_wait = 0; m_rptr = 0;
        m_rlen = rsp_len < 6 ? 6 : (rsp_len > MRSP ? MRSP : int'(rsp_len));
      end
      if (bus_wr && bus_sel == CTL) begin
        if (bus_wdata[5] && m_g) begin
          m_g = 0; m_ph = 0; m_cnt = 0; m_rptr = 0;
        end else if (bus_wdata[1]) m_g = 1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
    end
  endtask

  // running comparison against the model on every cycle (status layout, R4)
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) chk("R4 model", bus_rdata, m_rdata(bus_sel));
  end

  task automatic do_wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_sel = s; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_sel = STS; bus_wdata = 0;
  endtask
  task automatic do_rd(logic [1:0] s, output logic [31:0] v);
    @(negedge clk); bus_rd = 1; bus_sel = s; #2 v = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_sel = STS;
  endtask
  task automatic rd_chk(string tag, logic [1:0] s, logic [31:0] exp);
    logic [31:0] v;
    do_rd(s, v);
    chk(tag, v, exp);
  endtask
  task automatic send(byte unsigned b []);
    foreach (b[i]) do_wr(DAT, {24'b0, b[i]});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk("R1 control after reset", CTL, 32'h80);
    rd_chk("R1 status after reset", STS, 32'h0);
    rd_chk("R3 identifier", IDN, {DID, VID});
    do_wr(DAT, 32'h55);
    do_wr(STS, 32'h40);
    rd_chk("R13 status ungranted", STS, 32'h0);
    rd_chk("R13 data ungranted", DAT, 32'h0);

    do_wr(CTL, 32'h02);
    rd_chk("R2 control granted", CTL, 32'hA0);
    rd_chk("R4 granted idle status", STS, 32'h80);
    do_wr(STS, 32'h40);
    rd_chk("R4 ready state", STS, 32'h0006C8);

    send('{8'h80, 8'h01, 8'h00});
    rd_chk("R6 burst before header", STS, 32'h0003C8);
    send('{8'h00, 8'h00, 8'h0A});
    rd_chk("R6 burst after header", STS, 32'h0004C8);
    send('{8'h11, 8'h22, 8'h33});
    rd_chk("R5 expect held one short", STS, 32'h0001C8);
    send('{8'h44});
    rd_chk("R5 expect dropped at last byte", STS, 32'h0000C0);
    do_wr(DAT, 32'h99);
    rd_chk("R7 extra write ignored", STS, 32'h0000C0);

    rsp_len = 16'd8;
    do_wr(STS, 32'h20);
    repeat (EXC - 1) @(negedge clk);
    #2 chk("R9 still executing", bus_rdata, 32'h80);
    @(negedge clk);
    #2 chk("R9 data waiting on time", bus_rdata, 32'h000890);
    begin
      logic [7:0] exp_r [8] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h08, 8'h86, 8'h87};
      for (int i = 0; i < 8; i++) begin
        rd_chk("R10 reply byte", DAT, {24'b0, exp_r[i]});
        if (i == 3) rd_chk("R10 burst remaining", STS, 32'h000490);
      end
    end
    rd_chk("R11 drained status", STS, 32'h80);
    rd_chk("R11 empty read", DAT, 32'h0);
    rd_chk("R11 status after empty read", STS, 32'h80);

    do_wr(STS, 32'h40);
    rd_chk("R12 back to ready", STS, 32'h0006C8);
    send('{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03});
    rd_chk("R8 short length stops expect", STS, 32'h0000C0);
    do_wr(STS, 32'h20);
    repeat (EXC + 2) @(negedge clk);
    rd_chk("R8 start refused", STS, 32'h0000C0);

    do_wr(STS, 32'h40);
    send('{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h50});
    rd_chk("R8 long length stops expect", STS, 32'h0000C0);

    do_wr(STS, 32'h40);
    send('{8'h33, 8'h44, 8'h00, 8'h00, 8'h00, 8'h06});
    rsp_len = 16'd2;
    do_wr(STS, 32'h20);
    repeat (EXC + 1) @(negedge clk);
    rd_chk("R10 short length clamped", STS, 32'h000690);
    rd_chk("R10 echo byte 0", DAT, 32'h33);
    rd_chk("R10 echo byte 1", DAT, 32'h44);
    do_wr(STS, 32'h40);
    rd_chk("R12 abort during reply", STS, 32'h0006C8);
    rd_chk("R12 no data after abort", DAT, 32'h0);

    send('{8'hC1, 8'h02, 8'h00, 8'h00, 8'h00, 8'h06});
    rsp_len = 16'd100;
    do_wr(STS, 32'h20);
    do_wr(STS, 32'h40);
    rd_chk("R12 abort during execution", STS, 32'h0006C8);
    send('{8'hC1, 8'h02, 8'h00, 8'h00, 8'h00, 8'h06});
    do_wr(STS, 32'h20);
    repeat (EXC + 1) @(negedge clk);
    rd_chk("R10 long length clamped", STS, 32'h002090);
    for (int i = 0; i < MRSP; i++) begin
      do_rd(DAT, v);
      if (i == 5) chk("R10 length low byte", v, 32'h20);
      if (i == MRSP - 1) chk("R10 last filler byte", v, 32'hE0);
    end
    rd_chk("R11 drained after long reply", STS, 32'h80);

    do_wr(CTL, 32'h22);
    rd_chk("R2 released", CTL, 32'h80);
    rd_chk("R13 status after release", STS, 32'h0);
    do_wr(CTL, 32'h02);
    rd_chk("R2 regranted idle", STS, 32'h80);
    rd_chk("R3 identifier while held", IDN, {DID, VID});

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule